// File: doc/BRIEF.md
# Double-Precision Rounding and Exception Flag Stage

This block is the last stage of a floating-point datapath. An arithmetic unit hands it an exact result that has not yet been rounded. The result comes as a sign, a biased exponent with two extra signed bits of headroom for values below or above the normal range, a significand with its hidden bit, a guard bit, a round bit and a sticky bit. The block rounds that value under one of four directed or nearest modes and packs it into the interchange format. By default that format is binary64: 1 sign bit, 11 exponent bits and 52 fraction bits. The block also raises the overflow, underflow and inexact flags that go with the result.

Results below the normal range are shifted into subnormal form, so underflow is gradual. The bits shifted out are folded into the sticky information. A rounding carry can lift a subnormal to the smallest normal, and it can lift the largest binade to overflow. Both cases are encoded correctly. Operands that are already special (NaN or infinity) are flagged by the producer and forwarded bit for bit. This keeps quiet and signalling NaN payloads exactly as they arrived.

The stage is a single register: every input accepted with `in_valid` appears one clock later with `out_valid`. The widths are parameters, so the same code serves smaller formats.

Top module: `fp_round_pack`

## Requirements
- R1: A synchronous reset clears `out_valid`, `out_val` and all flags. Otherwise `out_valid` equals `in_valid` from the previous clock, and the outputs of an accepted input appear on that same cycle.
- R2: `in_mode` selects the rounding: 0 rounds to nearest with ties to even, 1 rounds toward zero, 2 rounds toward +infinity and 3 rounds toward -infinity. The result is the format value that this rule selects from the exact value sig.grs × 2^(exp−bias−FW).
- R3: When `in_exp` is below 1, the significand is shifted right by 1−`in_exp` into subnormal form (exponent field 0). Every bit shifted out counts toward the sticky bit before rounding.
- R4: If rounding carries a subnormal up to 2^FW units, the result has exponent field 1 and fraction 0. A carry out of a normal significand increments the exponent field and clears the fraction.
- R5: Overflow is flagged when the exponent after rounding reaches the all-ones field. The result is then infinity for mode 0, for mode 2 with a positive sign and for mode 3 with a negative sign. In every other case it is the largest finite value of the same sign (exponent all-ones minus 1, fraction all ones).
- R6: `out_inexact` is set exactly when the guard bit, the round bit, the sticky bit or any bit shifted out is nonzero, or when overflow occurs.
- R7: `out_underflow` is set exactly when the value is tiny and `out_inexact` is also set. Tiny means the unrounded exponent is below 1.
- R8: A zero significand produces a zero with the input sign and clears all flags, whatever the exponent, the rounding bits and the mode.
- R9: With `in_pass` set, `out_val` equals `in_pass_val` exactly, all flags are clear and the mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input result present |
| in_sign | input | 1 | Sign of the unrounded result |
| in_exp | input | EW+2 | Signed biased exponent of the unrounded result |
| in_sig | input | FW+1 | Significand with hidden bit at the MSB; zero means a zero value |
| in_grs | input | 3 | Guard, round and sticky bits, guard at bit 2 |
| in_mode | input | 2 | Rounding mode, encoded as in R2 |
| in_pass | input | 1 | Forward `in_pass_val` unchanged (NaN or infinity) |
| in_pass_val | input | 1+EW+FW | Already-encoded special value |
| out_valid | output | 1 | Result present |
| out_val | output | 1+EW+FW | Packed sign, exponent field, fraction |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The hardest cases to produce from the ports are rounding carries at boundaries. One is a carry that turns a subnormal into the smallest normal. The other is a carry out of the top binade into overflow, combined with a sign and mode that select infinity or the largest finite value. The bench uses a small format with a 4-bit exponent and a 3-bit fraction. It sweeps every significand, every guard/round/sticky pattern, both signs and all four modes, across exponents from deep below the subnormal range to well past overflow. As a result, every carry boundary is hit under every mode. The expected value is computed in the bench from the exact scaled integer, by dividing it by the quantum of the target binade.

// File: rtl/fp_round_pack.sv
module fp_round_pack #(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sign,
  input  logic signed [EW+1:0] in_exp,
  input  logic [FW:0]          in_sig,
  input  logic [2:0]           in_grs,
  input  logic [1:0]           in_mode,
  input  logic                 in_pass,
  input  logic [EW+FW:0]       in_pass_val,
  output logic                 out_valid,
  output logic [EW+FW:0]       out_val,
  output logic                 out_overflow,
  output logic                 out_underflow,
  output logic                 out_inexact
);
  localparam int XW = EW + 2;
  localparam int W  = FW + 3;
  localparam logic [EW-1:0] EALL = '1;
  localparam logic [EW-1:0] EBIG = EALL - 1'b1;
  localparam logic signed [XW-1:0] EMAX = $signed({2'b00, EALL});
  localparam logic signed [XW-1:0] ONE  = 1;
  localparam logic [XW-1:0] WLIM = XW'(W);

  logic          zero, tiny, lost, g, st, inc, carry, ovf, nx, to_inf;
  logic [XW-1:0] shamt, shc;
  logic [W-1:0]  raw, sft, mask;
  logic [FW+1:0] sum;
  logic signed [XW-1:0] exp_n;
  logic [EW-1:0] efield;
  logic [EW+FW:0] res;

  assign zero  = (in_sig == '0);
  assign tiny  = (in_exp < ONE);
  assign shamt = ONE - in_exp;
  assign shc   = (shamt > WLIM) ? WLIM : shamt;
  assign raw   = {in_sig, in_grs[2], |in_grs[1:0]};
  assign mask  = ~({W{1'b1}} << shc);
  assign sft   = tiny ? (raw >> shc) : raw;
  assign lost  = tiny & |(raw & mask);
  assign g     = sft[1];
  assign st    = sft[0] | lost;

  always_comb begin
    case (in_mode)
      2'd0:    inc = g & (st | sft[2]);
      2'd1:    inc = 1'b0;
      2'd2:    inc = ~in_sign & (g | st);
      default: inc = in_sign & (g | st);
    endcase
  end

  assign sum    = {1'b0, sft[W-1:2]} + {{(FW+1){1'b0}}, inc};
  assign carry  = sum[FW+1];
  assign exp_n  = in_exp + {{(XW-1){1'b0}}, carry};
  assign ovf    = ~zero & ~tiny & (exp_n >= EMAX);
  assign nx     = ~zero & (g | st | ovf);
  assign efield = tiny ? {{(EW-1){1'b0}}, sum[FW]} : exp_n[EW-1:0];
  assign to_inf = (in_mode == 2'd0) | ((in_mode == 2'd2) & ~in_sign) |
                  ((in_mode == 2'd3) & in_sign);

  always_comb begin
    if (in_pass)      res = in_pass_val;
    else if (zero)    res = {in_sign, {(EW+FW){1'b0}}};
    else if (ovf)     res = to_inf ? {in_sign, EALL, {FW{1'b0}}}
                                   : {in_sign, EBIG, {FW{1'b1}}};
    else              res = {in_sign, efield, sum[FW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_val       <= '0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
      out_inexact   <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      out_val       <= res;
      out_overflow  <= ~in_pass & ovf;
      out_underflow <= ~in_pass & tiny & nx;
      out_inexact   <= ~in_pass & nx;
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid)) else $error("out_valid mismatch");

  assert_pass_exact_R9: assert property (@(posedge clk) disable iff (rst)
    $past(in_pass) |-> (out_val == $past(in_pass_val)) &&
                       !out_overflow && !out_underflow && !out_inexact)
    else $error("pass-through altered");

  assert_uf_needs_nx_R7: assert property (@(posedge clk) disable iff (rst)
    out_underflow |-> out_inexact) else $error("underflow without inexact");

  assert_ovf_nx_R6: assert property (@(posedge clk) disable iff (rst)
    out_overflow |-> out_inexact && (out_val[EW+FW-1:FW] >= EBIG))
    else $error("overflow encoding or inexact wrong");

  assert_rz_no_inf_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(in_mode) == 2'd1 && !$past(in_pass)) |-> (out_val[EW+FW-1:FW] != EALL))
    else $error("toward-zero produced infinity");

  assert_zero_clean_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!in_pass && in_sig == '0)) |->
      (out_val[EW+FW-1:0] == '0) && (out_val[EW+FW] == $past(in_sign)) &&
      !out_overflow && !out_underflow && !out_inexact)
    else $error("zero handling wrong");
endmodule

// File: tb/fp_round_pack_bench.sv
module fp_round_pack_bench;
  localparam int EW = 4;
  localparam int FW = 3;
  localparam int TW = 1 + EW + FW;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_sign = 0, in_pass = 0;
  logic signed [EW+1:0] in_exp = '0;
  logic [FW:0] in_sig = '0;
  logic [2:0] in_grs = '0;
  logic [1:0] in_mode = '0;
  logic [TW-1:0] in_pass_val = '0;
  logic out_valid, out_overflow, out_underflow, out_inexact;
  logic [TW-1:0] out_val;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp_round_pack #(.EW(EW), .FW(FW)) u_fp_round_pack (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .in_grs(in_grs), .in_mode(in_mode),
    .in_pass(in_pass), .in_pass_val(in_pass_val), .out_valid(out_valid),
    .out_val(out_val), .out_overflow(out_overflow),
    .out_underflow(out_underflow), .out_inexact(out_inexact));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input bit s, input int e, input int sig, input int grs, input int mode);
    @(negedge clk);
    in_valid = 1; in_pass = 0; in_sign = s; in_exp = (EW+2)'(e);
    in_sig = (FW+1)'(sig); in_grs = 3'(grs); in_mode = 2'(mode);
    @(negedge clk);
  endtask

  task automatic run_vec(input bit s, input int e, input int sig, input int grs, input int mode);
    longint x, q, k, rem, half, rq;
    int eb, ee, frac;
    bit up, ovf, tiny, nx;
    logic [TW-1:0] expv;
    string tag;
    drive(s, e, sig, grs, mode);
    x    = longint'((sig << 3) | grs) << (e + 6);
    eb   = (e > 1) ? e : 1;
    q    = longint'(1) << (eb - 1 + 10);
    k    = x / q;
    rem  = x % q;
    half = q >> 1;
    case (mode)
      0: up = (rem > half) || (rem == half && k[0]);
      1: up = 0;
      2: up = !s && rem != 0;
      default: up = s && rem != 0;
    endcase
    k  = k + longint'(up);
    rq = k << (eb - 1);
    tiny = x < (longint'(8) << 10);
    if (rq < 8) begin ee = 0; frac = int'(rq); end
    else begin
      ee = 1;
      while (rq >= (longint'(16) << (ee - 1))) ee++;
      frac = int'(rq >> (ee - 1)) - 8;
    end
    ovf = ee >= 15;
    nx  = (rem != 0) || ovf;
    if (ovf) begin
      if (mode == 0 || (mode == 2 && !s) || (mode == 3 && s)) expv = {s, 4'hF, 3'h0};
      else expv = {s, 4'hE, 3'h7};
      tag = "R5";
    end else begin
      expv = {s, 4'(ee), 3'(frac)};
      tag = tiny ? ((ee != 0) ? "R4" : "R3") : (up && ee > e ? "R4" : "R2");
    end
    check(tag, out_val, expv);
    check("R1", out_valid, 1);
    check("R5", out_overflow, ovf);
    check("R6", out_inexact, nx);
    check("R7", out_underflow, tiny && nx);
  endtask

  task automatic run_pass(input logic [TW-1:0] v, input int mode);
    @(negedge clk);
    in_valid = 1; in_pass = 1; in_pass_val = v; in_mode = 2'(mode);
    in_sig = 4'hB; in_exp = 6'sd3; in_grs = 3'b111;
    @(negedge clk);
    check("R9", out_val, v);
    check("R9", {out_overflow, out_underflow, out_inexact}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {out_valid, out_overflow, out_underflow, out_inexact}, 0);
    check("R1", out_val, 0);
    rst = 0;
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        for (int e = -6; e <= 17; e++)
          for (int sig = 8; sig < 16; sig++)
            for (int grs = 0; grs < 8; grs++)
              run_vec(s[0], e, sig, grs, m);
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        for (int e = -5; e <= 16; e += 7)
          for (int grs = 0; grs < 8; grs += 3) begin
            drive(s[0], e, 0, grs, m);
            check("R8", out_val, {s[0], 7'h0});
            check("R8", {out_overflow, out_underflow, out_inexact}, 0);
          end
    for (int m = 0; m < 4; m++) begin
      run_pass(8'h7C, m);
      run_pass(8'hF9, m);
      run_pass(8'h78, m);
      run_pass(8'hF8, m);
    end
    @(negedge clk);
    in_valid = 0; in_pass = 0;
    @(negedge clk);
    check("R1", out_valid, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule